// File: doc/BRIEF.md
# Multi-Mode Packing Transmit FIFO

This block is the transmit-side sample queue of a serial port that can run as a plain byte link, as an 8-bit or 16-bit audio codec link, or as a 20-bit-slot audio link. The bus side is a 32-bit write port. One write can deliver several samples at once, and each sample is cut from a fixed lane of the bus word. The serial side takes one sample at a time, together with a code that gives its width. The storage holds 32 byte samples in the two byte modes and 16 wider samples in the two wide modes.

A write brings its own sample count. The block checks that count against the current mode. Illegal counts are dropped without effect. A legal write that does not fit in the free space is refused as a whole and raises a sticky overrun flag. Fill level, full and empty are registered. A transmitter reset or any change of the mode field empties the queue.

Top module: `txpack_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `fill_level`=0 and `overrun`=0.
- R2: In mode 00 (byte link) and mode 01 (8-bit codec) the capacity is `BYTE_DEPTH` (32) samples, and `full` is 1 exactly when 32 are held.
- R3: Byte-mode lanes: a count of 1 takes bus bits 31–24. A count of 2 takes 31–24, then 23–16. A count of 4 takes 31–24, 23–16, 15–8, then 7–0, in that pop order. Each sample pops with `rd_wcode`=0 (8-bit) and appears on `rd_data[7:0]`, with the upper bits zero.
- R4: In mode 10 (16-bit codec) the capacity is 16. A count of 1 takes bits 31–16. A count of 2 takes 31–16, then 15–0. Each sample pops with `rd_wcode`=1 (16-bit) on `rd_data[15:0]`.
- R5: In mode 11 (20-bit slots) the capacity is 16, and one slot is written per bus write. The slot is bits 31–12 and pops with `rd_wcode`=2. With `wr_short`=1 the slot is bits 31–16 instead and pops with `rd_wcode`=1 on `rd_data[15:0]`.
- R6: A write whose count is illegal for the mode is ignored and sets no overrun. The legal counts are 1, 2 and 4 in byte modes, 1 and 2 in mode 10, and only 1 in mode 11.
- R7: A legal write that needs more entries than are free is refused as a whole: none of its samples is stored, and `overrun` becomes 1.
- R8: `overrun` stays 1 until a transmitter reset or a mode change.
- R9: `tx_reset` empties the queue and clears `overrun`. It takes priority over a write in the same cycle.
- R10: A change of `mode_sel` empties the queue and clears `overrun`. A write presented in that cycle is dropped.
- R11: While the queue is not empty, `rd_data` and `rd_wcode` show the oldest sample, and `rd_en` removes it. `rd_en` on an empty queue has no effect. A push and a pop in the same cycle both take effect, and free space is judged before the pop.
- R12: `fill_level`, `full` and `empty` take their new values at the clock edge that performs the push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode: 00 byte link, 01 8-bit codec, 10 16-bit codec, 11 20-bit slots |
| tx_reset | input | 1 | Synchronous transmitter reset, empties the queue |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Bus write word |
| wr_cnt | input | 3 | Samples carried by this write (1, 2 or 4) |
| wr_short | input | 1 | Mode 11 only: the slot is a 16-bit slot from bits 31–16 |
| rd_en | input | 1 | Pop the oldest sample |
| rd_data | output | 20 | Oldest sample, right-aligned |
| rd_wcode | output | 2 | Width of the oldest sample: 0 = 8, 1 = 16, 2 = 20 bits |
| empty | output | 1 | Queue holds no sample |
| full | output | 1 | Queue holds the capacity of the current mode |
| fill_level | output | 6 | Number of samples held |
| overrun | output | 1 | Sticky: a write was refused for lack of space |

## Verification
A corrupted write or read pointer shows up at the next pop: the bytes come out in the wrong lane order, or with a width code from the wrong mode. The scoreboard catches this on the first sample that differs. A bad level count shows on `fill_level`, `full` or `empty` one edge after the push or pop. It also shows later as an overrun that is missing or comes too early at the capacity limit. A flush that fails shows as stale samples popped in the first cycle after the reset or the mode change.

// File: rtl/txpk_pkg.sv
package txpk_pkg;
   typedef enum logic [1:0] {
      MD_BYTE    = 2'b00,
      MD_CODEC8  = 2'b01,
      MD_CODEC16 = 2'b10,
      MD_SLOT20  = 2'b11
   } txpk_mode_e;

   localparam logic [1:0] WC_8  = 2'd0;
   localparam logic [1:0] WC_16 = 2'd1;
   localparam logic [1:0] WC_20 = 2'd2;

   localparam int BUS_W = 32;
   localparam int SMP_W = 20;
   localparam int LANES = 4;

   typedef struct packed {
      logic [1:0]       wcode;
      logic [SMP_W-1:0] data;
   } txpk_ent_t;
endpackage

// File: rtl/txpk_unpack.sv
module txpk_unpack
   import txpk_pkg::*;
(
   input  txpk_mode_e                   mode,
   input  logic [BUS_W-1:0]             bus,
   input  logic [2:0]                   cnt,
   input  logic                         short_slot,
   output txpk_ent_t [LANES-1:0]        smp,
   output logic [2:0]                   n_push
);
   logic byte_mode;
   assign byte_mode = (mode == MD_BYTE) || (mode == MD_CODEC8);

   always_comb begin
      n_push = 3'd0;
      if (byte_mode) begin
         if (cnt == 3'd1 || cnt == 3'd2 || cnt == 3'd4) n_push = cnt;
      end else if (mode == MD_CODEC16) begin
         if (cnt == 3'd1 || cnt == 3'd2) n_push = cnt;
      end else begin
         if (cnt == 3'd1) n_push = cnt;
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : gen_lane
      logic [7:0]  b_lane;
      logic [15:0] h_lane;
      assign b_lane = bus[BUS_W-1-8*k -: 8];
      if (k < 2) begin : gen_half
         assign h_lane = bus[BUS_W-1-16*k -: 16];
      end else begin : gen_nohalf
         assign h_lane = 16'd0;
      end

      always_comb begin
         smp[k] = '0;
         if (byte_mode) begin
            smp[k] = '{wcode: WC_8, data: {12'd0, b_lane}};
         end else if (mode == MD_CODEC16) begin
            if (k < 2) smp[k] = '{wcode: WC_16, data: {4'd0, h_lane}};
         end else if (k == 0) begin
            if (short_slot) smp[k] = '{wcode: WC_16, data: {4'd0, bus[31:16]}};
            else            smp[k] = '{wcode: WC_20, data: bus[31:12]};
         end
      end
   end
endmodule

// File: rtl/txpk_store.sv
module txpk_store
   import txpk_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic [2:0]                     push_n,
   input  txpk_ent_t [LANES-1:0]          push_data,
   input  logic                           pop,
   output txpk_ent_t                      head,
   output logic [$clog2(DEPTH):0]         level
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = AW + 1;

   txpk_ent_t       mem [DEPTH];
   logic [AW-1:0]   wp, rp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         wp    <= wp + AW'(push_n);
         rp    <= rp + AW'(pop);
         level <= level + LW'(push_n) - LW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (!clr) begin
         for (int k = 0; k < LANES; k++) begin
            if (k < int'(push_n)) mem[wp + AW'(k)] <= push_data[k];
         end
      end
   end

   assign head = mem[rp];
endmodule

// File: rtl/txpack_fifo.sv
module txpack_fifo
   import txpk_pkg::*;
#(
   parameter int BYTE_DEPTH = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     mode_sel,
   input  logic                           tx_reset,
   input  logic                           wr_en,
   input  logic [31:0]                    wr_data,
   input  logic [2:0]                     wr_cnt,
   input  logic                           wr_short,
   input  logic                           rd_en,
   output logic [19:0]                    rd_data,
   output logic [1:0]                     rd_wcode,
   output logic                           empty,
   output logic                           full,
   output logic [$clog2(BYTE_DEPTH):0]    fill_level,
   output logic                           overrun
);
   localparam int WIDE_DEPTH = BYTE_DEPTH / 2;
   localparam int LW         = $clog2(BYTE_DEPTH) + 1;

   if (BYTE_DEPTH < 8 || (BYTE_DEPTH & (BYTE_DEPTH - 1)) != 0) begin : gen_bad_depth
      $error("BYTE_DEPTH must be a power of two of at least 8");
   end

   txpk_mode_e            mode_q;
   logic                  mode_chg, clr;
   logic [LW-1:0]         cap, free;
   txpk_ent_t [LANES-1:0] smp;
   logic [2:0]            n_req, push_n;
   logic                  req_ok, fits, pop_ok;
   txpk_ent_t             head;

   assign mode_chg = (mode_sel != mode_q);
   assign clr      = tx_reset || mode_chg;
   assign cap      = mode_q[1] ? LW'(WIDE_DEPTH) : LW'(BYTE_DEPTH);
   assign free     = cap - fill_level;

   txpk_unpack u_unpack (
      .mode       (mode_q),
      .bus        (wr_data),
      .cnt        (wr_cnt),
      .short_slot (wr_short),
      .smp        (smp),
      .n_push     (n_req)
   );

   assign req_ok = wr_en && (n_req != 3'd0) && !clr;
   assign fits   = LW'(n_req) <= free;
   assign push_n = (req_ok && fits) ? n_req : 3'd0;
   assign pop_ok = rd_en && (fill_level != '0) && !clr;

   txpk_store #(.DEPTH(BYTE_DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push_n    (push_n),
      .push_data (smp),
      .pop       (pop_ok),
      .head      (head),
      .level     (fill_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MD_BYTE;
         overrun <= 1'b0;
      end else begin
         mode_q <= txpk_mode_e'(mode_sel);
         if (clr)                 overrun <= 1'b0;
         else if (req_ok && !fits) overrun <= 1'b1;
      end
   end

   assign empty    = (fill_level == '0);
   assign full     = (fill_level == cap);
   assign rd_data  = head.data;
   assign rd_wcode = head.wcode;
endmodule

// File: rtl/txpack_fifo_chk.sv
module txpack_fifo_chk #(
   parameter int BYTE_DEPTH = 32
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [1:0]                     mode_sel,
   input logic [1:0]                     mode_q,
   input logic                           tx_reset,
   input logic                           wr_en,
   input logic [2:0]                     wr_cnt,
   input logic                           rd_en,
   input logic                           empty,
   input logic                           full,
   input logic [$clog2(BYTE_DEPTH):0]    level,
   input logic                           overrun
);
   localparam int LW = $clog2(BYTE_DEPTH) + 1;
   logic [LW-1:0] cap;
   assign cap = mode_q[1] ? LW'(BYTE_DEPTH / 2) : LW'(BYTE_DEPTH);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= cap); // R2
   AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset |=> (level == '0 && !overrun)); // R9
   AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != mode_q) |=> (level == '0 && !overrun)); // R10
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !tx_reset && mode_sel == mode_q) |=> overrun); // R8
   AST_REJECT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_reset && mode_sel == mode_q && !mode_q[1] && wr_cnt == 3'd4
       && level > LW'(BYTE_DEPTH - 4) && !rd_en) |=> ($stable(level) && overrun)); // R7
   AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_reset && mode_sel == 2'b11 && mode_q == 2'b11 && wr_cnt != 3'd1
       && !rd_en) |=> $stable(level)); // R6
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en && !tx_reset) |=> empty); // R11
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !empty); // R12
endmodule

bind txpack_fifo txpack_fifo_chk #(.BYTE_DEPTH(BYTE_DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .mode_q   (mode_q),
   .tx_reset (tx_reset),
   .wr_en    (wr_en),
   .wr_cnt   (wr_cnt),
   .rd_en    (rd_en),
   .empty    (empty),
   .full     (full),
   .level    (fill_level),
   .overrun  (overrun)
);

// File: tb/test_txpack_fifo.sv
module test_txpack_fifo;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic        tx_reset = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  wr_cnt = 3'd1;
   logic        wr_short = 1'b0;
   logic        rd_en = 1'b0;
   logic [19:0] rd_data;
   logic [1:0]  rd_wcode;
   logic        empty, full, overrun;
   logic [5:0]  fill_level;

   int errors = 0;
   int checks = 0;
   logic [21:0] exp_q[$];
   logic exp_ovr = 1'b0;
   string cur_req = "R3";

   always #(CLK_PERIOD/2) clk = ~clk;

   txpack_fifo i_txpack_fifo (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_reset(tx_reset),
      .wr_en(wr_en), .wr_data(wr_data), .wr_cnt(wr_cnt), .wr_short(wr_short),
      .rd_en(rd_en), .rd_data(rd_data), .rd_wcode(rd_wcode), .empty(empty),
      .full(full), .fill_level(fill_level), .overrun(overrun)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compares each sample popped against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rd_en && !empty) begin
         if (exp_q.size() == 0) begin
            check({cur_req, " unexpected pop"}, {10'd0, rd_wcode, rd_data}, 32'hDEAD);
         end else begin
            check({cur_req, " sample"}, {10'd0, rd_wcode, rd_data}, {10'd0, exp_q.pop_front()});
         end
      end
   end

   function automatic int cap_of(input logic [1:0] m);
      return m[1] ? 16 : 32;
   endfunction

   // driver: models acceptance from the requirements and fills the scoreboard
   task automatic model_write(input logic [2:0] cnt, input logic [31:0] d, input logic sh);
      int n = 0;
      logic [21:0] s[4];
      if (mode_sel[1] == 1'b0) begin
         if (cnt == 1 || cnt == 2 || cnt == 4) n = cnt;
         for (int k = 0; k < 4; k++) s[k] = {2'd0, 12'd0, d[31-8*k -: 8]};
      end else if (mode_sel == 2'b10) begin
         if (cnt == 1 || cnt == 2) n = cnt;
         s[0] = {2'd1, 4'd0, d[31:16]};
         s[1] = {2'd1, 4'd0, d[15:0]};
      end else begin
         if (cnt == 1) n = 1;
         s[0] = sh ? {2'd1, 4'd0, d[31:16]} : {2'd2, d[31:12]};
      end
      if (n != 0) begin
         if (n > cap_of(mode_sel) - exp_q.size()) exp_ovr = 1'b1;
         else for (int k = 0; k < n; k++) exp_q.push_back(s[k]);
      end
   endtask

   task automatic bus_write(input logic [2:0] cnt, input logic [31:0] d, input logic sh, input logic also_pop);
      model_write(cnt, d, sh);
      wr_en = 1'b1; wr_cnt = cnt; wr_data = d; wr_short = sh; rd_en = also_pop;
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0; wr_short = 1'b0;
   endtask

   task automatic pop_n(input int n);
      rd_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic check_flags(input string req);
      @(negedge clk);
      check({req, " level"}, 32'(fill_level), 32'(exp_q.size()));
      check({req, " empty"}, 32'(empty), 32'(exp_q.size() == 0));
      check({req, " full"}, 32'(full), 32'(exp_q.size() == cap_of(mode_sel)));
      check({req, " overrun"}, 32'(overrun), 32'(exp_ovr));
      @(posedge clk); #1;
   endtask

   task automatic change_mode(input logic [1:0] m);
      mode_sel = m; wr_en = 1'b1; wr_cnt = 3'd1; wr_data = 32'hFFFF_FFFF;
      @(posedge clk); #1;
      wr_en = 1'b0;
      exp_q.delete(); exp_ovr = 1'b0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_flags("R1");
      rst_n = 1'b1;
      @(posedge clk); #1;
      check_flags("R1");

      // R3 lane order in byte mode
      cur_req = "R3";
      bus_write(3'd4, 32'hA1B2C3D4, 1'b0, 1'b0);
      bus_write(3'd2, 32'h11223344, 1'b0, 1'b0);
      bus_write(3'd1, 32'h55667788, 1'b0, 1'b0);
      check_flags("R12");
      pop_n(7);
      check_flags("R3");

      // R2 capacity, R7 whole refusal, R8 sticky overrun
      cur_req = "R2";
      for (int i = 0; i < 8; i++) bus_write(3'd4, 32'h01020304 + 32'(i) * 32'h10101010, 1'b0, 1'b0);
      check_flags("R2");
      bus_write(3'd1, 32'hEE000000, 1'b0, 1'b0);
      check_flags("R7");
      pop_n(3);
      bus_write(3'd4, 32'h99999999, 1'b0, 1'b0);
      check_flags("R7");
      bus_write(3'd2, 32'hABCD0000, 1'b0, 1'b0);
      check_flags("R8");
      pop_n(31);
      check_flags("R8");

      // R9 transmitter reset wins over a write
      bus_write(3'd2, 32'h12340000, 1'b0, 1'b0);
      tx_reset = 1'b1; wr_en = 1'b1; wr_cnt = 3'd4;
      @(posedge clk); #1;
      tx_reset = 1'b0; wr_en = 1'b0;
      exp_q.delete(); exp_ovr = 1'b0;
      check_flags("R9");

      // R10 mode change flush, write in that cycle dropped
      bus_write(3'd4, 32'h0BADF00D, 1'b0, 1'b0);
      change_mode(2'b10);
      check_flags("R10");

      // R4 16-bit codec, R6 illegal count
      cur_req = "R4";
      bus_write(3'd2, 32'h12345678, 1'b0, 1'b0);
      bus_write(3'd1, 32'hABCD0000, 1'b0, 1'b0);
      bus_write(3'd4, 32'hFFFFFFFF, 1'b0, 1'b0);
      check_flags("R6");
      pop_n(3);
      for (int i = 0; i < 8; i++) bus_write(3'd2, 32'h1000_2000 + 32'(i), 1'b0, 1'b0);
      check_flags("R4");
      bus_write(3'd1, 32'h77770000, 1'b0, 1'b0);
      check_flags("R7");
      change_mode(2'b11);
      check_flags("R10");

      // R5 20-bit slots and short slot, R6 illegal count
      cur_req = "R5";
      bus_write(3'd1, 32'hFEDCB123, 1'b0, 1'b0);
      bus_write(3'd1, 32'h98765432, 1'b1, 1'b0);
      bus_write(3'd2, 32'h11111111, 1'b0, 1'b0);
      check_flags("R6");
      pop_n(2);
      check_flags("R5");

      // R11 pop on empty, push with pop, full with pop
      cur_req = "R11";
      pop_n(1);
      check_flags("R11");
      bus_write(3'd1, 32'h00001000, 1'b0, 1'b0);
      bus_write(3'd1, 32'h00002000, 1'b0, 1'b1);
      check_flags("R11");
      for (int i = 0; i < 15; i++) bus_write(3'd1, 32'h3000_0000 + (32'(i) << 12), 1'b0, 1'b0);
      check_flags("R5");
      bus_write(3'd1, 32'h44440000, 1'b0, 1'b1);
      check_flags("R11");
      pop_n(15);
      check_flags("R11");

      summary();
   end
endmodule